// File: doc/BRIEF.md
# SPI Host Serial Controller

This block is a memory-mapped SPI host for a CPU. Software loads words into an 8-entry transmit queue. A shift engine serialises each word on `sclk` and `mosi` and samples `miso`, and the received words collect in an 8-entry receive queue for software to read. A control register sets the word width (2 to 16 bits), the bit order, the clock phase and polarity, internal loopback, host mode, enable, a soft reset and whether each queue is enabled. A 16-bit divisor sets the serial clock rate. An interrupt output goes high once all queued data has been shifted out. Chip select is not part of this block; a separate general-purpose output drives it.

The shift engine is a three-state machine. In `SH_IDLE`, `sclk` rests at the polarity level. When the engine runs and the transmit queue holds a word, it pops that word, freezes the control and divisor settings for the frame, and moves to `SH_FIRST`. When a half-period expires it moves from `SH_FIRST` to `SH_SECOND`. At the end of `SH_FIRST` it samples a bit; at the end of `SH_SECOND` it moves the next bit out. After the last bit, `SH_SECOND` returns to `SH_FIRST` with a fresh word if one is waiting, or goes back to `SH_IDLE`. A soft reset forces `SH_IDLE` from any state.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, all registers read 0. The status register reads 0x0A (both queues empty, engine idle). `sclk`, `mosi` and `irq` are low.
- R2: Register offsets are: 0x04 transmit data (a write pushes one word), 0x08 receive data (a read pops one word), 0x0C status, 0x10 control, 0x14 divisor, 0x18 interrupt enable. Control and divisor read back as written. Status bits are: 0 transmit full, 1 transmit empty, 2 receive full, 3 receive empty, 4 engine busy.
- R3: Control bits [3:0] hold the width minus one, and each frame carries exactly that many bits. Control bit 4 set sends MSB first; clear sends LSB first. A received word sits in the low bits of the receive register, with the first bit received at the top of the word when MSB first.
- R4: Control bit 6 sets the idle level of `sclk`. With control bit 5 clear, `miso` is sampled on the edge that leaves the idle level; with it set, on the edge that returns to it. Each frame has two `sclk` edges per bit.
- R5: Each `sclk` half-period lasts exactly the divisor value in clocks. A divisor of 0 gives 65536 clocks.
- R6: With control bit 10 set, the sampled data is the block's own `mosi`. With it clear, the data comes from the `miso` pin.
- R7: `irq` is high when interrupt-enable bit 2 is set, the transmit queue is empty and the engine is idle. Writing 0 to the interrupt-enable register drops it.
- R8: A write to a full transmit queue is dropped. A read of an empty receive queue returns 0 and changes nothing. A received word that arrives when the receive queue is full is dropped.
- R9: A frame starts only when control bits 9 (enable) and 8 (host) are both set, soft reset is clear, and a word is queued. Queued words follow each other with no extra `sclk` time between frames.
- R10: While control bit 7 is set, both queues are emptied, any frame is abandoned, and `sclk` rests at the polarity level.
- R11: A control or divisor write during a frame takes effect only at the next frame.
- R12: Control bits 11 and 12 enable the full depth of the transmit and receive queues. When a bit is clear, that queue holds only one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus access this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data, valid in the cycle of the access |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Transmit-drained interrupt |

## Verification
The bench goes after the edges of the frame timing. A wrong phase shows up as a `mosi` word captured one bit off. An off-by-one in the divisor counter gives edge gaps of the divisor plus or minus one. A zero divisor handled as zero instead of 65536 gives a run-away or stuck clock. It also fills the transmit queue past its depth and reads the receive queue empty; a design without overflow guards would send the ninth word or drift its pointers. It rewrites the width in the middle of a frame, which a design without a frozen frame configuration would cut short. It asserts soft reset during a frame, after which a word must not appear in the receive queue.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    localparam int WORD_W = 16;
    localparam int DIV_W  = 17;
    localparam int CTL_W  = 13;

    localparam logic [4:0] OFS_TXD  = 5'h04;
    localparam logic [4:0] OFS_RXD  = 5'h08;
    localparam logic [4:0] OFS_STAT = 5'h0C;
    localparam logic [4:0] OFS_CTL  = 5'h10;
    localparam logic [4:0] OFS_DIV  = 5'h14;
    localparam logic [4:0] OFS_IEN  = 5'h18;

    localparam int B_MSB  = 4;
    localparam int B_CPHA = 5;
    localparam int B_CPOL = 6;
    localparam int B_SRST = 7;
    localparam int B_HOST = 8;
    localparam int B_EN   = 9;
    localparam int B_LOOP = 10;
    localparam int B_TXQ  = 11;
    localparam int B_RXQ  = 12;

    typedef enum logic [1:0] {SH_IDLE, SH_FIRST, SH_SECOND} sh_state_t;

    typedef struct packed {
        logic [3:0]       wm1;
        logic             msb_first;
        logic             cpha;
        logic             cpol;
        logic             loopback;
        logic [DIV_W-1:0] div;
    } frame_cfg_t;
endpackage

// File: rtl/spi_host_fifo.sv
module spi_host_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         limit_one,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = limit_one ? !empty : (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp_q] <= wdata;
    end

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (cnt_q == $past(cnt_q))); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH)); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R10
endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter
    import spi_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              run,
    input  logic              tx_avail,
    input  frame_cfg_t        cfg_live,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              miso,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic              busy
);
    sh_state_t         state_q, state_d;
    frame_cfg_t        cfg_q;
    logic [DIV_W-1:0]  cnt_q;
    logic [3:0]        bit_q;
    logic [WORD_W-1:0] tsr_q, rsr_q;
    logic              half_done, last_bit, start, frame_end, out_bit, samp;
    logic [3:0]        pad;

    assign half_done = (cnt_q == '0);
    assign last_bit  = (bit_q == cfg_q.wm1);
    assign start     = run && tx_avail;
    assign frame_end = (state_q == SH_SECOND) && half_done && last_bit;
    assign tx_pop    = !soft_rst && start && ((state_q == SH_IDLE) || frame_end);
    assign rx_push   = !soft_rst && frame_end;
    assign out_bit   = cfg_q.msb_first ? tsr_q[cfg_q.wm1] : tsr_q[0];
    assign samp      = cfg_q.loopback ? out_bit : miso;
    assign pad       = 4'(WORD_W - 1) - cfg_q.wm1;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SH_IDLE:   if (start) state_d = SH_FIRST;
            SH_FIRST:  if (half_done) state_d = SH_SECOND;
            SH_SECOND: if (half_done) begin
                if (!last_bit)   state_d = SH_FIRST;
                else if (start)  state_d = SH_FIRST;
                else             state_d = SH_IDLE;
            end
            default:   state_d = SH_IDLE;
        endcase
        if (soft_rst) state_d = SH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            cnt_q <= '0;
            bit_q <= '0;
            tsr_q <= '0;
            rsr_q <= '0;
        end else if (soft_rst) begin
            cnt_q <= '0;
            bit_q <= '0;
        end else if (tx_pop) begin
            cfg_q <= cfg_live;
            tsr_q <= tx_word;
            rsr_q <= '0;
            cnt_q <= cfg_live.div - 1'b1;
            bit_q <= '0;
        end else if (state_q != SH_IDLE) begin
            if (half_done) begin
                cnt_q <= cfg_q.div - 1'b1;
                if (state_q == SH_FIRST) begin
                    rsr_q <= cfg_q.msb_first ? {rsr_q[WORD_W-2:0], samp}
                                             : {samp, rsr_q[WORD_W-1:1]};
                end else begin
                    tsr_q <= cfg_q.msb_first ? {tsr_q[WORD_W-2:0], 1'b0}
                                             : {1'b0, tsr_q[WORD_W-1:1]};
                    bit_q <= bit_q + 4'd1;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        busy    = (state_q != SH_IDLE);
        mosi    = busy && out_bit;
        rx_word = cfg_q.msb_first ? (rsr_q & ({WORD_W{1'b1}} >> pad)) : (rsr_q >> pad);
        if (!busy)           sclk = cfg_live.cpol;
        else if (cfg_q.cpha) sclk = cfg_q.cpol ^ (state_q == SH_FIRST);
        else                 sclk = cfg_q.cpol ^ (state_q == SH_SECOND);
    end

    AST_SCLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !half_done && !tx_pop && !soft_rst) |=> $stable(sclk)); // R5
    AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !busy); // R10
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && start && !soft_rst) |=> busy); // R9
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tx_pop) |=> $stable(cfg_q)); // R11
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic [15:0]       rsp_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              irq
);
    logic [CTL_W-1:0]  ctl_q;
    logic [15:0]       div_q;
    logic              ien_q;
    logic              wr, rd, soft_rst, run, busy;
    logic              tx_full, tx_empty, rx_full, rx_empty;
    logic              tx_pop, rx_push;
    logic [WORD_W-1:0] tx_head, rx_head, rx_word;
    frame_cfg_t        cfg_live;
    logic [4:0]        status;

    assign wr       = req_valid && req_write;
    assign rd       = req_valid && !req_write;
    assign soft_rst = ctl_q[B_SRST];
    assign run      = ctl_q[B_EN] && ctl_q[B_HOST] && !soft_rst;

    always_comb begin
        cfg_live.wm1       = ctl_q[3:0];
        cfg_live.msb_first = ctl_q[B_MSB];
        cfg_live.cpha      = ctl_q[B_CPHA];
        cfg_live.cpol      = ctl_q[B_CPOL];
        cfg_live.loopback  = ctl_q[B_LOOP];
        cfg_live.div       = (div_q == '0) ? DIV_W'(1 << 16) : DIV_W'(div_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            div_q <= '0;
            ien_q <= 1'b0;
        end else if (wr) begin
            if (req_addr == ADDR_W'(OFS_CTL)) ctl_q <= req_wdata[CTL_W-1:0];
            if (req_addr == ADDR_W'(OFS_DIV)) div_q <= req_wdata;
            if (req_addr == ADDR_W'(OFS_IEN)) ien_q <= req_wdata[2];
        end
    end

    spi_host_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) tx_q_i (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst), .limit_one(!ctl_q[B_TXQ]),
        .push(wr && (req_addr == ADDR_W'(OFS_TXD))), .wdata(req_wdata),
        .pop(tx_pop), .rdata(tx_head), .full(tx_full), .empty(tx_empty));

    spi_host_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) rx_q_i (
        .clk(clk), .rst_n(rst_n), .flush(soft_rst), .limit_one(!ctl_q[B_RXQ]),
        .push(rx_push), .wdata(rx_word),
        .pop(rd && (req_addr == ADDR_W'(OFS_RXD))), .rdata(rx_head),
        .full(rx_full), .empty(rx_empty));

    spi_host_shifter shift_i (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .run(run),
        .tx_avail(!tx_empty), .cfg_live(cfg_live), .tx_word(tx_head), .miso(miso),
        .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .busy(busy));

    assign status = {busy, rx_empty, rx_full, tx_empty, tx_full};
    assign irq    = ien_q && tx_empty && !busy;

    always_comb begin
        rsp_rdata = '0;
        if (rd) begin
            if (req_addr == ADDR_W'(OFS_RXD) && !rx_empty) rsp_rdata = rx_head;
            if (req_addr == ADDR_W'(OFS_STAT)) rsp_rdata = 16'(status);
            if (req_addr == ADDR_W'(OFS_CTL))  rsp_rdata = 16'(ctl_q);
            if (req_addr == ADDR_W'(OFS_DIV))  rsp_rdata = div_q;
            if (req_addr == ADDR_W'(OFS_IEN))  rsp_rdata = {13'b0, ien_q, 2'b0};
        end
    end

    AST_IRQ_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !irq); // R7
endmodule

// File: tb/spi_host_ctrl_tb_top.sv
module spi_host_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [15:0] req_wdata = '0, rsp_rdata;
    logic        sclk, mosi, irq;
    logic        miso = 1'b0;

    int checks = 0, fails = 0;
    int cyc = 0, edges = 0, samples = 0, last_edge = 0, last_gap = 0, max_gap = 0;
    logic        prev_sclk = 1'b0;
    logic [15:0] cap = '0;
    logic        tb_cpha = 1'b0, tb_cpol = 1'b0;

    always #2.5 clk = ~clk;

    spi_host_ctrl dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .irq(irq));

    // vector: {divisor[3:0], wm1[3:0], msb, cpha, cpol, word[15:0]}
    localparam logic [26:0] VEC [8] = '{
        {4'd7,  4'd7,  1'b1, 1'b0, 1'b0, 16'h00A5},
        {4'd8,  4'd7,  1'b0, 1'b0, 1'b0, 16'h0037},
        {4'd7,  4'd15, 1'b1, 1'b1, 1'b0, 16'hBEEF},
        {4'd9,  4'd15, 1'b0, 1'b1, 1'b1, 16'h1234},
        {4'd7,  4'd3,  1'b1, 1'b0, 1'b1, 16'h000B},
        {4'd10, 4'd1,  1'b0, 1'b1, 1'b0, 16'h0002},
        {4'd7,  4'd11, 1'b1, 1'b1, 1'b1, 16'h0ABC},
        {4'd12, 4'd8,  1'b0, 1'b0, 1'b1, 16'h01C3}};

    always @(negedge clk) begin
        cyc++;
        if (rst_n && sclk !== prev_sclk) begin
            if (edges > 0) begin
                last_gap = cyc - last_edge;
                if (last_gap > max_gap) max_gap = last_gap;
            end
            edges++;
            last_edge = cyc;
            if ((!tb_cpha && sclk != tb_cpol) || (tb_cpha && sclk == tb_cpol)) begin
                cap = {cap[14:0], mosi};
                samples++;
            end
        end
        prev_sclk = sclk;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1 d = rsp_rdata;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic mon_clear();
        #1;
        edges = 0; samples = 0; cap = '0; max_gap = 0; last_gap = 0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 4000; i++) begin
            bus_rd(5'h0C, s);
            if (s[1] && !s[4]) break;
        end
    endtask

    function automatic logic [15:0] mk_ctl(input logic [3:0] wm1, input logic msb, cpha, cpol,
                                           srst, host, en, loopb, txq, rxq);
        return {3'b0, rxq, txq, loopb, en, host, srst, cpol, cpha, msb, wm1};
    endfunction

    function automatic logic [15:0] width_mask(input logic [3:0] wm1);
        return 16'hFFFF >> (4'd15 - wm1);
    endfunction

    function automatic logic [15:0] rev_bits(input logic [15:0] w, input logic [3:0] wm1);
        logic [15:0] r = '0;
        for (int i = 0; i <= int'(wm1); i++) r[int'(wm1) - i] = w[i];
        return r;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] d, s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        bus_rd(5'h0C, s); check("R1 status", s, 16'h000A);
        bus_rd(5'h10, d); check("R1 ctl", d, 0);
        check("R1 pins", {sclk, mosi, irq}, 3'b000);
        // R2: readback
        bus_wr(5'h14, 16'h1234); bus_rd(5'h14, d); check("R2 divisor readback", d, 16'h1234);
        bus_wr(5'h10, 16'h0A5F); bus_rd(5'h10, d); check("R2 ctl readback", d, 16'h0A5F);
        bus_wr(5'h10, 16'h0);

        // vector table: R3 R4 R5 R6 in loopback
        for (int v = 0; v < 8; v++) begin
            logic [3:0] wm1 = VEC[v][22:19];
            logic [15:0] w = VEC[v][15:0];
            logic [15:0] mosi_exp;
            tb_cpha = VEC[v][17]; tb_cpol = VEC[v][16];
            bus_wr(5'h14, 16'(VEC[v][26:23]));
            bus_wr(5'h10, mk_ctl(wm1, VEC[v][18], tb_cpha, tb_cpol, 0, 1, 1, 1, 1, 1));
            mon_clear();
            bus_wr(5'h04, w);
            wait_idle();
            mosi_exp = VEC[v][18] ? (w & width_mask(wm1)) : rev_bits(w, wm1);
            bus_rd(5'h08, d); check("R6 R3 loopback word", d, w & width_mask(wm1));
            check("R3 mosi order", cap & width_mask(wm1), mosi_exp);
            check("R4 sample edges", samples, int'(wm1) + 1);
            check("R4 edges per frame", edges, 2 * (int'(wm1) + 1));
            check("R5 half period", max_gap, 32'(VEC[v][26:23]));
        end

        // R6: loopback off, pin data
        tb_cpha = 0; tb_cpol = 0;
        bus_wr(5'h14, 16'd7);
        miso = 1'b1;
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 0, 1, 1, 0, 1, 1));
        bus_wr(5'h04, 16'h0000); wait_idle();
        bus_rd(5'h08, d); check("R6 miso high", d, 16'h00FF);
        miso = 1'b0;
        bus_wr(5'h04, 16'h00FF); wait_idle();
        bus_rd(5'h08, d); check("R6 miso low", d, 16'h0000);

        // R9: host bit clear blocks the frame
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 0, 0, 1, 1, 1, 1));
        mon_clear();
        bus_wr(5'h04, 16'h005A);
        repeat (40) @(negedge clk);
        check("R9 no frame without host", edges, 0);
        bus_rd(5'h0C, s); check("R9 word still queued", s[1], 0);
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 0, 1, 1, 1, 1, 1));
        wait_idle(); bus_rd(5'h08, d); check("R9 frame after host", d, 16'h005A);

        // R9: back-to-back frames
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 0, 0, 0, 1, 1, 1));
        bus_wr(5'h04, 16'h0011); bus_wr(5'h04, 16'h0022); bus_wr(5'h04, 16'h0033);
        mon_clear();
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 0, 1, 1, 1, 1, 1));
        wait_idle();
        check("R9 edges for three words", edges, 48);
        check("R9 no gap between frames", max_gap, 7);
        for (int i = 0; i < 3; i++) begin
            bus_rd(5'h08, d); check("R9 burst order", d, 16'h0011 * (i + 1));
        end

        // R7: interrupt
        mon_clear();
        bus_wr(5'h04, 16'h0066);
        bus_wr(5'h18, 16'h0004);
        check("R7 irq low while shifting", irq, 0);
        wait_idle();
        @(negedge clk); check("R7 irq after drain", irq, 1);
        bus_wr(5'h18, 16'h0000);
        check("R7 irq masked", irq, 0);
        bus_rd(5'h08, d);

        // R11: ctl change mid-frame
        mon_clear();
        bus_wr(5'h04, 16'h00A5);
        repeat (20) @(negedge clk);
        bus_wr(5'h10, mk_ctl(4'd15, 1, 0, 0, 0, 1, 1, 1, 1, 1));
        wait_idle();
        check("R11 frame keeps old width", edges, 16);
        bus_rd(5'h08, d); check("R11 old-width word", d, 16'h00A5);
        mon_clear();
        bus_wr(5'h04, 16'hC3A5); wait_idle();
        check("R11 new width next frame", edges, 32);
        bus_rd(5'h08, d); check("R11 new-width word", d, 16'hC3A5);

        // R8: overflow and underflow
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 0, 0, 0, 1, 1, 1));
        for (int i = 0; i < 9; i++) bus_wr(5'h04, 16'h0010 + 16'(i));
        bus_rd(5'h0C, s); check("R8 tx full flag", s[0], 1);
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 0, 1, 1, 1, 1, 1));
        wait_idle();
        bus_rd(5'h0C, s); check("R8 rx full flag", s[2], 1);
        for (int i = 0; i < 8; i++) begin
            bus_rd(5'h08, d); check("R8 kept words", d, 16'h0010 + 16'(i));
        end
        bus_rd(5'h08, d); check("R8 empty read returns 0", d, 0);
        bus_rd(5'h0C, s); check("R8 status after empty read", s, 16'h000A);

        // R12: queue enables clear -> one word each
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 0, 0, 0, 1, 0, 0));
        bus_wr(5'h04, 16'h0071);
        bus_rd(5'h0C, s); check("R12 tx full at one word", s[0], 1);
        bus_wr(5'h04, 16'h0072);
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 0, 1, 1, 1, 0, 0));
        wait_idle();
        bus_rd(5'h08, d); check("R12 single word kept", d, 16'h0071);
        bus_rd(5'h0C, s); check("R12 second word dropped", s, 16'h000A);

        // R10: soft reset flushes and parks sclk
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 0, 0, 0, 1, 1, 1));
        bus_wr(5'h04, 16'h0001); bus_wr(5'h04, 16'h0002);
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 1, 1, 0, 0, 1, 1, 1));
        bus_rd(5'h0C, s); check("R10 queues flushed", s, 16'h000A);
        check("R10 sclk at polarity", sclk, 1);
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 0, 1, 1, 1, 1, 1));
        bus_wr(5'h04, 16'h0044);
        repeat (10) @(negedge clk);
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 1, 1, 1, 1, 1, 1));
        bus_rd(5'h0C, s); check("R10 frame abandoned", s, 16'h000A);
        bus_wr(5'h10, mk_ctl(4'd7, 1, 0, 0, 0, 1, 1, 1, 1, 1));
        repeat (150) @(negedge clk);
        bus_rd(5'h0C, s); check("R10 no word after reset", s, 16'h000A);

        // R5: divisor 0 means 65536
        tb_cpha = 1; tb_cpol = 0;
        bus_wr(5'h14, 16'h0000);
        bus_wr(5'h10, mk_ctl(4'd1, 1, 1, 0, 0, 1, 1, 1, 1, 1));
        mon_clear();
        bus_wr(5'h04, 16'h0001);
        for (int i = 0; i < 70000 && edges < 2; i++) @(negedge clk);
        check("R5 zero divisor half period", last_gap, 65536);
        bus_wr(5'h10, mk_ctl(4'd1, 1, 1, 0, 1, 0, 0, 1, 1, 1));

        summary();
        $finish;
    end
endmodule